// File: doc/BRIEF.md
# Tagged Cut-Through Read Return Buffer

This block serves one DMA read at a time for a PCI-style target that needs data from system memory. A read request from the target side is turned into one upstream command for the whole 64-byte memory block that holds the requested address. The command carries this unit's ID as its tag, and it is marked interlocked when the lock input was high at the time the request was accepted.

Return data comes back on a bus that several units share. Each beat is 16 bytes, and the beats of one block arrive in address order. The block keeps only the beats whose tag equals its own ID and writes them into a single 64-byte buffer. A cut-through threshold, given in whole beats, sets how much of the block must be in the buffer before 32-bit words are handed to the target side. After delivery has started, later beats keep filling the buffer while earlier words are sent out. If delivery catches up with arrival, the target side is stalled.

The buffer is freed only when all four beats have arrived and all sixteen words have been delivered. Only then is a new request accepted.

Top module: `rd_return_buf`

## Requirements
- R1: A request is accepted only on a cycle when `req_ready_o` is high. While a read is in progress `req_ready_o` stays low, and `req_valid_i` has no effect on the command that has already been issued.
- R2: In the cycle after a request is accepted, `up_valid_o` goes high with `up_addr_o` equal to the request address with its six low bits cleared. Both hold until the cycle after an edge on which `up_ready_i` is high.
- R3: `up_tag_o` equals the unit ID parameter (default 4'h5) whenever `up_valid_o` is high.
- R4: `up_ilock_o` equals the value `req_lock_i` had at acceptance, for the whole time the command is presented.
- R5: A return beat whose tag differs from the unit ID is ignored. So is any beat that arrives while no command has been handshaken. An ignored beat changes neither the buffered data nor the timing of `pci_valid_o`.
- R6: The n-th captured beat (n = 0 to 3) supplies words 4n to 4n+3. Word 4n+k is bits [32k+31:32k] of that beat. Words reach `pci_data_o` in ascending order.
- R7: `thresh_i` is sampled at acceptance. A value t (0 to 3) means t+1 beats. `pci_valid_o` first rises in the cycle after the edge that captures beat number t+1.
- R8: `pci_valid_o` is never high for a word whose beat has not been captured. When delivery has caught up with arrival, it stays low until the next matching beat.
- R9: After delivery has started, matching beats are still captured on the same edges on which words are handed over.
- R10: `req_ready_o` rises in the cycle after the handshake of the sixteenth word, and not before.
- R11: `pci_last_o` is high only together with `pci_valid_o`, and only for the sixteenth word.
- R12: During reset `req_ready_o` is 1, and `up_valid_o` and `pci_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request from the target side |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_lock_i | input | 1 | Lock; when high, the read is issued as interlocked |
| thresh_i | input | THR_W | Cut-through threshold minus one, in beats |
| req_ready_o | output | 1 | Buffer free; a request is accepted |
| up_valid_o | output | 1 | Upstream read command valid |
| up_ready_i | input | 1 | Upstream takes the command |
| up_addr_o | output | ADDR_W | Block-aligned read address |
| up_tag_o | output | TAG_W | Tag of this unit |
| up_ilock_o | output | 1 | Interlocked read |
| ret_valid_i | input | 1 | Beat valid on the shared return bus |
| ret_tag_i | input | TAG_W | Tag of the return beat |
| ret_data_i | input | BEAT_W | Return beat data |
| pci_valid_o | output | 1 | Word available to the target side |
| pci_ready_i | input | 1 | Target side takes the word |
| pci_data_o | output | DW | Delivered word |
| pci_last_o | output | 1 | Last word of the block |

## Verification
Every output comes from a register, so each result is due exactly one edge after its cause. The upstream command follows acceptance by one cycle. A word becomes valid one cycle after the capture that completes the threshold or makes the word available. The buffer is free one cycle after the final word handshake. The bench drives inputs on the falling edge and moves its own queue-free model on the rising edge. It compares every output against that model on the next falling edge, which is where each of these one-cycle results can first be seen. Foreign-tag beats, stalls and holds on the upstream command are checked the same way, together with targeted checks at the ports.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2
  } rrb_state_e;
endpackage

// File: rtl/rrb_ctrl.sv
module rrb_ctrl
  import rrb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] UNIT_ID = 'h5,
  parameter int BLK_BYTES = 64,
  parameter int THR_W = 2,
  parameter int BCNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_lock_i,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic              up_ready_i,
  input  logic              done_i,
  output logic              req_ready_o,
  output logic              up_valid_o,
  output logic [ADDR_W-1:0] up_addr_o,
  output logic [TAG_W-1:0]  up_tag_o,
  output logic              up_ilock_o,
  output logic              fill_o,
  output logic [BCNT_W-1:0] thr_beats_o
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  rrb_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              lock_q;
  logic [BCNT_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      lock_q <= 1'b0;
      thr_q  <= BCNT_W'(1);
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q   <= ST_ISSUE;
          addr_q <= {req_addr_i[ADDR_W-1:OFF_W], OFF_W'(0)};
          lock_q <= req_lock_i;
          thr_q  <= BCNT_W'(thresh_i) + BCNT_W'(1);
        end
        ST_ISSUE: if (up_ready_i) st_q <= ST_FILL;
        ST_FILL:  if (done_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign up_valid_o  = (st_q == ST_ISSUE);
  assign up_addr_o   = addr_q;
  assign up_tag_o    = UNIT_ID;
  assign up_ilock_o  = lock_q;
  assign fill_o      = (st_q == ST_FILL);
  assign thr_beats_o = thr_q;

  // R1: an accepted request leads to a command on the next cycle
  a_r1_accept_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i |=> up_valid_o);

  // R2, R4: command held stable until taken
  a_r2_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o && !up_ready_i |=> up_valid_o && $stable(up_addr_o) && $stable(up_ilock_o));
endmodule

// File: rtl/rrb_store.sv
module rrb_store #(
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] UNIT_ID = 'h5,
  parameter int BEAT_W = 128,
  parameter int DW = 32,
  parameter int BEATS = 4,
  parameter int BCNT_W = 3,
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic              clr_i,
  input  logic              ret_valid_i,
  input  logic [TAG_W-1:0]  ret_tag_i,
  input  logic [BEAT_W-1:0] ret_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BCNT_W-1:0] beats_o,
  output logic [DW-1:0]     rd_data_o
);
  localparam int WPB   = BEAT_W / DW;
  localparam int WORDS = BEATS * WPB;

  logic [BCNT_W-1:0]          beats_q;
  logic [WORDS-1:0][DW-1:0]   mem_q;
  logic [WORDS-1:0]           we;
  logic                       cap;

  assign cap = fill_i && ret_valid_i && (ret_tag_i == UNIT_ID)
            && (beats_q < BCNT_W'(BEATS));

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar k = 0; k < WPB; k++) begin : g_word
      assign we[b*WPB+k] = cap && (beats_q == BCNT_W'(b));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    beats_q <= '0;
    else if (clr_i) beats_q <= '0;
    else if (cap)   beats_q <= beats_q + BCNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < WORDS; w++) begin
      if (we[w]) mem_q[w] <= ret_data_i[(w % WPB)*DW +: DW];
    end
  end

  assign beats_o   = beats_q;
  assign rd_data_o = mem_q[rd_idx_i];

  // R9: fill count never drops during a read
  a_r9_fill_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !clr_i |=> beats_o >= $past(beats_o));
endmodule

// File: rtl/rrb_drain.sv
module rrb_drain #(
  parameter int BEATS = 4,
  parameter int WPB = 4,
  parameter int BCNT_W = 3,
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [BCNT_W-1:0] beats_i,
  input  logic [BCNT_W-1:0] thr_i,
  input  logic              pci_ready_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              pci_valid_o,
  output logic              pci_last_o,
  output logic              done_o
);
  localparam int SH    = $clog2(WPB);
  localparam int WORDS = BEATS * WPB;

  logic [IDX_W-1:0]  rd_q;
  logic [BCNT_W-1:0] rd_beat;
  logic              hs;

  assign rd_beat     = BCNT_W'(rd_q >> SH);
  assign pci_valid_o = fill_i && (beats_i >= thr_i) && (rd_beat < beats_i);
  assign hs          = pci_valid_o && pci_ready_i;
  assign pci_last_o  = pci_valid_o && (rd_q == IDX_W'(WORDS-1));
  assign done_o      = hs && pci_last_o;
  assign rd_idx_o    = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (done_o) rd_q <= '0;
    else if (hs)     rd_q <= rd_q + IDX_W'(1);
  end

  // R8: an offered word stays offered until taken
  a_r8_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_valid_o && !pci_ready_i |=> pci_valid_o && $stable(rd_idx_o));

  // R11
  a_r11_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_last_o |-> pci_valid_o);
endmodule

// File: rtl/rd_return_buf.sv
module rd_return_buf #(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] UNIT_ID = 'h5,
  parameter int BLK_BYTES = 64,
  parameter int BEAT_W = 128,
  parameter int DW = 32,
  localparam int BEATS = BLK_BYTES * 8 / BEAT_W,
  localparam int THR_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_lock_i,
  input  logic [THR_W-1:0]  thresh_i,
  output logic              req_ready_o,
  output logic              up_valid_o,
  input  logic              up_ready_i,
  output logic [ADDR_W-1:0] up_addr_o,
  output logic [TAG_W-1:0]  up_tag_o,
  output logic              up_ilock_o,
  input  logic              ret_valid_i,
  input  logic [TAG_W-1:0]  ret_tag_i,
  input  logic [BEAT_W-1:0] ret_data_i,
  output logic              pci_valid_o,
  input  logic              pci_ready_i,
  output logic [DW-1:0]     pci_data_o,
  output logic              pci_last_o
);
  localparam int WPB    = BEAT_W / DW;
  localparam int WORDS  = BEATS * WPB;
  localparam int BCNT_W = $clog2(BEATS + 1);
  localparam int IDX_W  = $clog2(WORDS);

  logic              fill;
  logic              done;
  logic [BCNT_W-1:0] thr_beats;
  logic [BCNT_W-1:0] beats;
  logic [IDX_W-1:0]  rd_idx;

  rrb_ctrl #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .UNIT_ID(UNIT_ID),
    .BLK_BYTES(BLK_BYTES), .THR_W(THR_W), .BCNT_W(BCNT_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_lock_i(req_lock_i), .thresh_i(thresh_i),
    .up_ready_i(up_ready_i), .done_i(done),
    .req_ready_o(req_ready_o), .up_valid_o(up_valid_o),
    .up_addr_o(up_addr_o), .up_tag_o(up_tag_o), .up_ilock_o(up_ilock_o),
    .fill_o(fill), .thr_beats_o(thr_beats)
  );

  rrb_store #(
    .TAG_W(TAG_W), .UNIT_ID(UNIT_ID), .BEAT_W(BEAT_W), .DW(DW),
    .BEATS(BEATS), .BCNT_W(BCNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .fill_i(fill), .clr_i(done),
    .ret_valid_i(ret_valid_i), .ret_tag_i(ret_tag_i), .ret_data_i(ret_data_i),
    .rd_idx_i(rd_idx), .beats_o(beats), .rd_data_o(pci_data_o)
  );

  rrb_drain #(
    .BEATS(BEATS), .WPB(WPB), .BCNT_W(BCNT_W), .IDX_W(IDX_W)
  ) u_drain (
    .clk_i(clk_i), .rst_ni(rst_ni), .fill_i(fill),
    .beats_i(beats), .thr_i(thr_beats), .pci_ready_i(pci_ready_i),
    .rd_idx_o(rd_idx), .pci_valid_o(pci_valid_o), .pci_last_o(pci_last_o),
    .done_o(done)
  );

  // R10: the buffer frees only right after the final word handshake
  a_r10_free_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> $past(pci_last_o && pci_valid_o && pci_ready_i));
endmodule

// File: tb/test_rd_return_buf.sv
module test_rd_return_buf;
  localparam logic [3:0] ID = 4'h5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_lock = 1'b0;
  logic [1:0]   thresh = '0;
  logic         up_ready = 1'b0;
  logic         ret_valid = 1'b0;
  logic [3:0]   ret_tag = '0;
  logic [127:0] ret_data = '0;
  logic         pci_ready = 1'b0;
  logic         req_ready, up_valid, up_ilock, pci_valid, pci_last;
  logic [31:0]  up_addr, pci_data;
  logic [3:0]   up_tag;

  always #10 clk = ~clk;

  rd_return_buf #(.UNIT_ID(ID)) i_rd_return_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_lock_i(req_lock),
    .thresh_i(thresh), .req_ready_o(req_ready),
    .up_valid_o(up_valid), .up_ready_i(up_ready), .up_addr_o(up_addr),
    .up_tag_o(up_tag), .up_ilock_o(up_ilock),
    .ret_valid_i(ret_valid), .ret_tag_i(ret_tag), .ret_data_i(ret_data),
    .pci_valid_o(pci_valid), .pci_ready_i(pci_ready),
    .pci_data_o(pci_data), .pci_last_o(pci_last)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit ovl_seen = 1'b0;

  // behavioural model
  int          m_st, m_beats, m_rd, m_thr;
  logic [31:0] m_addr;
  logic        m_lock;
  logic [31:0] m_mem [16];

  function automatic bit exp_pv();
    return (m_st == 2) && (m_beats >= m_thr) && (m_rd < m_beats * 4);
  endfunction

  function automatic logic [127:0] beat_data(input logic [31:0] a, input int b);
    logic [127:0] d;
    for (int k = 0; k < 4; k++)
      d[32*k +: 32] = 32'hA5C3_0000 ^ a ^ (32'h0101_0101 * (b * 4 + k + 1));
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_beats = 0; m_rd = 0; m_thr = 1; m_addr = '0; m_lock = 1'b0;
    end else begin
      bit pv, cap, hs;
      pv = exp_pv();
      case (m_st)
        0: if (req_valid) begin
          m_st = 1; m_addr = req_addr & 32'hFFFF_FFC0;
          m_lock = req_lock; m_thr = int'(thresh) + 1;
        end
        1: if (up_ready) m_st = 2;
        default: begin
          cap = ret_valid && (ret_tag == ID) && (m_beats < 4);
          hs  = pv && pci_ready;
          if (cap && hs) ovl_seen = 1'b1;
          if (cap) begin
            for (int k = 0; k < 4; k++) m_mem[m_beats*4+k] = ret_data[32*k +: 32];
            m_beats++;
          end
          if (hs) begin
            if (m_rd == 15) begin m_st = 0; m_beats = 0; m_rd = 0; end
            else m_rd++;
          end
        end
      endcase
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit pv;
      pv = exp_pv();
      chk(64'(req_ready), 64'(m_st == 0), "R1 R10 R12 req_ready");
      chk(64'(up_valid), 64'(m_st == 1), "R2 up_valid");
      if (m_st == 1) begin
        chk(64'(up_addr), 64'(m_addr), "R2 up_addr");
        chk(64'(up_tag), 64'(ID), "R3 up_tag");
        chk(64'(up_ilock), 64'(m_lock), "R4 up_ilock");
      end
      chk(64'(pci_valid), 64'(pv), "R7 R8 pci_valid");
      if (pv) begin
        chk(64'(pci_data), 64'(m_mem[m_rd]), "R6 R5 R9 pci_data");
        chk(64'(pci_last), 64'(m_rd == 15), "R11 pci_last");
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_read(input logic [31:0] a, input bit lk, input int thr,
                         input int up_dly, input int gap, input bit foreign,
                         input int prmode, input int hold);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_lock = lk; thresh = 2'(thr);
    @(negedge clk);
    req_valid = (hold > 0);
    req_addr = ~a; req_lock = ~lk;            // R1: ignored while busy
    for (int i = 0; i < up_dly; i++) begin
      @(negedge clk);
      if (i >= hold) req_valid = 1'b0;
    end
    up_ready = 1'b1;
    @(negedge clk);
    up_ready = 1'b0; req_valid = 1'b0;
    fork
      begin
        for (int b = 0; b < 4; b++) begin
          for (int g = 0; g < gap; g++) begin
            ret_valid = foreign; ret_tag = ID ^ 4'h3;
            ret_data = ~beat_data(a, b);
            @(negedge clk);
          end
          if (foreign && gap > 0 && b == 0)
            chk(64'(pci_valid), 64'd0, "R5 foreign beats ignored");
          ret_valid = 1'b1; ret_tag = ID; ret_data = beat_data(a, b);
          @(negedge clk);
        end
        ret_valid = 1'b0;
      end
      begin
        int c = 0;
        while (m_st != 0) begin
          pci_ready = (prmode == 0) ? 1'b1 : ((c % 3) != 0);
          c++;
          @(negedge clk);
        end
        pci_ready = 1'b0;
      end
    join
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(64'(req_ready), 64'd1, "R12 reset req_ready");
    chk(64'(up_valid), 64'd0, "R12 reset up_valid");
    chk(64'(pci_valid), 64'd0, "R12 reset pci_valid");
    rst_n = 1'b1;
    do_read(32'h1234_5678, 1'b0, 0, 0, 0, 1'b0, 0, 0);
    do_read(32'h0000_0FC7, 1'b1, 3, 3, 1, 1'b1, 1, 2);
    do_read(32'hFFFF_FFC0, 1'b0, 1, 1, 2, 1'b1, 0, 0);
    do_read(32'h8000_0040, 1'b1, 2, 0, 0, 1'b0, 1, 1);
    do_read(32'h0BAD_F00D, 1'b0, 0, 2, 3, 1'b1, 0, 0);
    chk(64'(ovl_seen), 64'd1, "R9 capture during delivery");
    chk(64'(req_ready), 64'd1, "R10 free at end");
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog act=hung exp=done");
    summary();
  end
endmodule